// File: doc/BRIEF.md
# Frequency Sweep Offset Generator

This block produces a linearly ramping frequency offset for a direct digital synthesizer. It keeps two working settings: a 32-bit step size and a 16-bit step interval. A down-counting interval divider paces an internal offset accumulator, which grows by the step size once per interval. While sweeping is enabled, the accumulated offset is added to an externally supplied base tuning word, and the registered sum is what the phase accumulator downstream receives. While sweeping is disabled, the base tuning word is forwarded unchanged and the offset is held at zero.

The step size and the interval sit on input buses. They are copied into the working settings only when the update strobe is high, so software can stage new values without disturbing a sweep in progress. The offset and the output sum both wrap modulo 2^32.

Top module: `freq_sweep_acc`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `ftw_out` is 0 and the working step size and interval are 0.
- R2: With `sweep_en` low, `ftw_out` equals the `base_ftw` value sampled at the previous rising clock edge.
- R3: `step_in` and `interval_in` are copied into the working settings only at a rising edge where `upd_strobe` is high. Changes on those buses with the strobe low have no effect on `ftw_out`.
- R4: With a working interval R, the offset grows by the working step size every R+1 clocks while `sweep_en` is high. The first increase happens at the (R+1)-th rising edge with `sweep_en` high, counting the first such edge as number 1.
- R5: An interval of 0 makes the offset grow by the step size at every clock while `sweep_en` is high.
- R6: With `sweep_en` high, `ftw_out` equals the sampled `base_ftw` plus the offset value held before that same edge. The output is registered, so it lags the offset by one clock.
- R7: The offset and the output sum both wrap modulo 2^32.
- R8: At an edge with `sweep_en` low, the offset returns to zero. After sweeping is re-enabled, the ramp starts again from zero with a full first interval.
- R9: If `upd_strobe` and an offset increase fall on the same edge, that increase uses the step size held before the strobe. The new step size applies from the next increase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sweep_en | input | 1 | Enables the frequency ramp |
| step_in | input | 32 | Staged step size added to the offset at each increase |
| interval_in | input | 16 | Staged interval: clocks between increases, minus one |
| upd_strobe | input | 1 | Copies the staged step size and interval into the working settings |
| base_ftw | input | 32 | Base frequency tuning word |
| ftw_out | output | 32 | Effective tuning word sent to the phase accumulator |

## Verification
The delicate case is an update strobe that lands on the same edge as an offset increase. The bench provokes it by running a sweep with an interval of 3 and raising the strobe, with a new step size on `step_in`, exactly on the fourth enabled edge, where the first increase occurs. It then compares `ftw_out` over the next intervals with a closed-form expectation. That expectation has the first increase use the old step size and every later increase use the new one. A design that applies the new step at once, or that loses the pending increase, produces a different output at the fifth and ninth edges.

// File: rtl/sweep_pkg.sv
`timescale 1ns/1ps
package sweep_pkg;
  localparam int unsigned DEF_FTW_W  = 32;
  localparam int unsigned DEF_RATE_W = 16;
endpackage

// File: rtl/sweep_shadow_regs.sv
`timescale 1ns/1ps
module sweep_shadow_regs #(
  parameter int unsigned FTW_W  = sweep_pkg::DEF_FTW_W,
  parameter int unsigned RATE_W = sweep_pkg::DEF_RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [FTW_W-1:0]  step_d,
  input  logic [RATE_W-1:0] rate_d,
  output logic [FTW_W-1:0]  step_q,
  output logic [RATE_W-1:0] rate_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      rate_q <= '0;
    end else if (load) begin
      step_q <= step_d;
      rate_q <= rate_d;
    end
  end

  // R3: working settings move only on a strobe
  assert_hold_no_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(step_q) && $stable(rate_q)));
  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> (step_q == $past(step_d) && rate_q == $past(rate_d)));
endmodule

// File: rtl/sweep_rate_div.sv
`timescale 1ns/1ps
module sweep_rate_div #(
  parameter int unsigned RATE_W = sweep_pkg::DEF_RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] interval,
  output logic              tick
);
  logic [RATE_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= interval;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4: after a tick the counter restarts from the working interval
  assert_reload_R4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == $past(interval)));
  // R4: while running and not ticking the counter only counts down
  assert_countdown_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !tick) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sweep_freq_accum.sv
`timescale 1ns/1ps
module sweep_freq_accum #(
  parameter int unsigned FTW_W = sweep_pkg::DEF_FTW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             step_now,
  input  logic [FTW_W-1:0] step,
  output logic [FTW_W-1:0] offset
);
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      offset <= '0;
    end else if (step_now) begin
      offset <= offset + step;
    end
  end

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (offset == '0));
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (run && step_now) |=> (offset == $past(offset) + $past(step)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !step_now) |=> $stable(offset));
endmodule

// File: rtl/freq_sweep_acc.sv
`timescale 1ns/1ps
module freq_sweep_acc #(
  parameter int unsigned FTW_W  = sweep_pkg::DEF_FTW_W,
  parameter int unsigned RATE_W = sweep_pkg::DEF_RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sweep_en,
  input  logic [FTW_W-1:0]  step_in,
  input  logic [RATE_W-1:0] interval_in,
  input  logic              upd_strobe,
  input  logic [FTW_W-1:0]  base_ftw,
  output logic [FTW_W-1:0]  ftw_out
);
  logic [FTW_W-1:0]  step_w;
  logic [RATE_W-1:0] rate_w;
  logic              step_tick;
  logic [FTW_W-1:0]  offset_w;

  sweep_shadow_regs #(.FTW_W(FTW_W), .RATE_W(RATE_W)) shadow_i (
    .clk(clk), .rst(rst), .load(upd_strobe),
    .step_d(step_in), .rate_d(interval_in),
    .step_q(step_w), .rate_q(rate_w)
  );

  sweep_rate_div #(.RATE_W(RATE_W)) div_i (
    .clk(clk), .rst(rst), .run(sweep_en),
    .interval(rate_w), .tick(step_tick)
  );

  sweep_freq_accum #(.FTW_W(FTW_W)) acc_i (
    .clk(clk), .rst(rst), .run(sweep_en),
    .step_now(step_tick), .step(step_w), .offset(offset_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ftw_out <= '0;
    end else if (sweep_en) begin
      ftw_out <= base_ftw + offset_w;
    end else begin
      ftw_out <= base_ftw;
    end
  end

  assert_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    !sweep_en |=> (ftw_out == $past(base_ftw)));
  assert_sum_R6: assert property (@(posedge clk) disable iff (rst)
    sweep_en |=> (ftw_out == $past(base_ftw) + $past(offset_w)));
  assert_reset_out_R1: assert property (@(posedge clk)
    rst |=> (ftw_out == '0));
endmodule

// File: tb/freq_sweep_acc_tb_top.sv
`timescale 1ns/1ps
module freq_sweep_acc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sweep_en = 1'b0;
  logic [31:0] step_in = '0;
  logic [15:0] interval_in = '0;
  logic        upd_strobe = 1'b0;
  logic [31:0] base_ftw = '0;
  logic [31:0] ftw_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  freq_sweep_acc dut_i (
    .clk(clk), .rst(rst), .sweep_en(sweep_en), .step_in(step_in),
    .interval_in(interval_in), .upd_strobe(upd_strobe),
    .base_ftw(base_ftw), .ftw_out(ftw_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ftw_out=%h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic program_regs(input logic [31:0] d, input logic [15:0] r);
    sweep_en = 1'b0;
    step_in = d;
    interval_in = r;
    upd_strobe = 1'b1;
    tick();
    upd_strobe = 1'b0;
    tick();
  endtask

  task automatic run_ramp(input string req, input logic [31:0] d, input int r,
                          input logic [31:0] b, input int n);
    base_ftw = b;
    sweep_en = 1'b1;
    for (int i = 1; i <= n; i++) begin
      tick();
      chk(req, ftw_out, b + d * 32'((i - 1) / (r + 1)));
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    base_ftw = 32'h1234_5678;
    repeat (3) tick();
    chk("R1", ftw_out, 32'h0);
    rst = 1'b0;
    sweep_en = 1'b1;
    tick();
    // working step and interval are zero: output is base with no offset
    chk("R1", ftw_out, 32'h1234_5678);
    tick();
    chk("R1", ftw_out, 32'h1234_5678);
    sweep_en = 1'b0;
    tick();
  endtask

  task automatic t_passthru();
    sweep_en = 1'b0;
    base_ftw = 32'hCAFE_0001;
    tick();
    chk("R2", ftw_out, 32'hCAFE_0001);
    base_ftw = 32'h0BAD_F00D;
    tick();
    chk("R2", ftw_out, 32'h0BAD_F00D);
  endtask

  task automatic t_rate_and_restart();
    program_regs(32'h0000_0100, 16'd3);
    run_ramp("R4", 32'h100, 3, 32'h1000_0000, 14);
    sweep_en = 1'b0;
    tick();
    chk("R8", ftw_out, 32'h1000_0000);
    run_ramp("R8", 32'h100, 3, 32'h1000_0000, 6);
    sweep_en = 1'b0;
    tick();
  endtask

  task automatic t_rate_zero();
    program_regs(32'h0000_0007, 16'd0);
    run_ramp("R5", 32'h7, 0, 32'h0000_0040, 6);
    sweep_en = 1'b0;
    tick();
  endtask

  task automatic t_sum();
    program_regs(32'h0001_0000, 16'd1);
    run_ramp("R6", 32'h1_0000, 1, 32'h2222_0000, 7);
    sweep_en = 1'b0;
    tick();
  endtask

  task automatic t_wrap();
    program_regs(32'h8000_0001, 16'd0);
    run_ramp("R7", 32'h8000_0001, 0, 32'hFFFF_FFF0, 5);
    sweep_en = 1'b0;
    tick();
  endtask

  task automatic t_strobe_gate();
    program_regs(32'h0000_0005, 16'd1);
    step_in = 32'h0000_0100;
    interval_in = 16'd0;
    run_ramp("R3", 32'h5, 1, 32'h0000_1000, 8);
    sweep_en = 1'b0;
    tick();
  endtask

  task automatic t_coincide();
    logic [31:0] exp;
    int s;
    program_regs(32'h0000_0010, 16'd3);
    base_ftw = 32'h0300_0000;
    sweep_en = 1'b1;
    for (int i = 1; i <= 12; i++) begin
      if (i == 4) begin
        step_in = 32'h0000_1000;
        upd_strobe = 1'b1;
      end else begin
        upd_strobe = 1'b0;
      end
      tick();
      s = (i - 1) / 4;
      exp = (s == 0) ? 32'h0300_0000
                     : 32'h0300_0000 + 32'h10 + 32'(s - 1) * 32'h1000;
      chk("R9", ftw_out, exp);
    end
    upd_strobe = 1'b0;
    sweep_en = 1'b0;
    tick();
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_passthru();
    t_rate_and_restart();
    t_rate_zero();
    t_sum();
    t_wrap();
    t_strobe_gate();
    t_coincide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule